// File: doc/BRIEF.md
# Slewed Gain Stage with Soft Mute

This block scales a stereo pair of 24-bit two's-complement audio samples by a gain chosen with a 7-bit attenuation code. A written code is not applied at once: a shared current-step register walks toward the wanted code one step at a time. Each step waits a fixed number of sample strobes, and that number depends on the selected speed mode. Because the gain never jumps, a volume change produces no click.

An active-low mute input sends the ramp toward the silent code. When mute is released, the ramp returns to the stored code. A code written while muted goes into the stored register only, and the ramp moves to it after mute is released. Both channels always use the same step value. Outputs are registered and are refreshed on the clock edge that carries the sample strobe.

Top module: `gr_soft_atten`

## Requirements
- R1: On each clock edge where `smp_tick` is high, each output takes its input scaled by the step value held before that edge. Step 0 passes the sample through unchanged. Step 127 gives 0. A step n in 1..126 gives floor(x·(127−n)/128), truncated to 24 bits.
- R2: `cur_step` changes by exactly one code per change and always moves toward the target. The target is the stored code when unmuted and 127 when muted.
- R3: With `hs_sel`=0, a step happens on the 8th strobe counted from the start of a ramp. With `hs_sel`=1, it happens on the 16th strobe. `cur_step` never changes in a cycle without a strobe.
- R4: A full ramp between codes 0 and 127 takes 1016 strobes with `hs_sel`=0 and 2032 strobes with `hs_sel`=1.
- R5: With `mute_n`=0, the step ramps to 127 and the outputs become 0. With `mute_n`=1, the step ramps back to the stored code and then holds there.
- R6: A write (`wr_en`=1) during mute updates only the stored code. The step keeps rising toward 127, and after release it ramps to the newly written code.
- R7: While `rst` is high, the stored code, `cur_step` and both outputs are 0, and mute is treated as inactive. After reset the gain is therefore unity.
- R8: When the ramp direction reverses, the strobe counter reloads. The first step in the new direction takes a full interval.
- R9: Both channels use the same step, so identical inputs give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle strobe per input sample period |
| hs_sel | input | 1 | 0: normal-speed interval, 1: high-speed interval |
| wr_en | input | 1 | Writes `wr_code` to the stored code register |
| wr_code | input | 7 | Attenuation code to store |
| mute_n | input | 1 | Active-low mute request |
| in_l | input | 24 | Left input sample |
| in_r | input | 24 | Right input sample |
| out_l | output | 24 | Scaled left sample |
| out_r | output | 24 | Scaled right sample |
| cur_step | output | 7 | Step value currently applied |

## Verification
The bench builds the block with its default intervals of 8 and 16 strobes. Both full-swing durations (1016 and 2032 strobes) therefore fit inside a short run and are timed exactly, in both directions. The scaling table walks the gain law at codes 0, 1, 63, 64, 126 and 127 with full-scale positive and negative samples. Directed sequences cover a mid-interval direction reversal, a write during mute, and a return to a new code after mute is released.

// File: rtl/gr_pkg.sv
package gr_pkg;
  localparam int CODE_W   = 7;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  typedef logic [CODE_W-1:0] code_t;

  // Gain numerator over 2**CODE_W: CODE_MAX - code (code 0 handled as bypass)
  function automatic logic [CODE_W:0] gain_num(input code_t code);
    return {1'b0, code_t'(CODE_MAX) - code};
  endfunction
endpackage

// File: rtl/gr_step_ctrl.sv
module gr_step_ctrl
  import gr_pkg::*;
#(
  parameter int NORM_INTERVAL = 8,
  parameter int HS_INTERVAL   = 16
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  hs_sel,
  input  code_t tgt,
  output code_t cur
);
  localparam int MAX_IV = (HS_INTERVAL > NORM_INTERVAL) ? HS_INTERVAL : NORM_INTERVAL;
  localparam int CNT_W  = $clog2(MAX_IV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  code_t            cur_q;
  logic             dir_q;
  logic             at_tgt;
  logic             go_up;

  assign lim    = hs_sel ? CNT_W'(HS_INTERVAL - 1) : CNT_W'(NORM_INTERVAL - 1);
  assign at_tgt = (cur_q == tgt);
  assign go_up  = (tgt > cur_q);
  assign cur    = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      dir_q <= go_up;
      if (at_tgt) begin
        cnt_q <= '0;
      end else if (go_up != dir_q) begin
        cnt_q <= tick ? CNT_W'(1) : '0;
      end else if (tick) begin
        if (cnt_q >= lim) begin
          cnt_q <= '0;
          cur_q <= go_up ? cur_q + code_t'(1) : cur_q - code_t'(1);
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (cur_q != $past(cur_q)) |-> (cur_q == $past(cur_q) + code_t'(1) ||
                                 cur_q == $past(cur_q) - code_t'(1))); // R2

  AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (cur_q != $past(cur_q)) |-> $past(tick)); // R3

  AST_STEP_TOWARD_TGT: assert property (@(posedge clk) disable iff (rst)
    (cur_q > $past(cur_q)) |-> ($past(tgt) > $past(cur_q))); // R2

  AST_RESET_STEP: assert property (@(posedge clk)
    rst |=> (cur_q == '0)); // R7
endmodule

// File: rtl/gr_chan_scale.sv
module gr_chan_scale
  import gr_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  code_t               code,
  input  logic [SAMPLE_W-1:0] din,
  output logic [SAMPLE_W-1:0] dout
);
  localparam int PROD_W = SAMPLE_W + CODE_W;

  logic signed [CODE_W:0]   num_s;
  logic signed [PROD_W-1:0] prod;
  logic [SAMPLE_W-1:0]      scaled;

  assign num_s = $signed(gain_num(code));

  always_comb begin
    prod   = $signed(din) * num_s;
    scaled = SAMPLE_W'(prod >>> CODE_W);
    if (code == '0) scaled = din;
  end

  always_ff @(posedge clk) begin
    if (rst)       dout <= '0;
    else if (tick) dout <= scaled;
  end

  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
    (tick && code == '0) |=> (dout == $past(din))); // R1

  AST_SILENT_CODE: assert property (@(posedge clk) disable iff (rst)
    (tick && code == code_t'(CODE_MAX)) |=> (dout == '0)); // R1

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(dout)); // R1
endmodule

// File: rtl/gr_soft_atten.sv
module gr_soft_atten
  import gr_pkg::*;
#(
  parameter int SAMPLE_W      = 24,
  parameter int NORM_INTERVAL = 8,
  parameter int HS_INTERVAL   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_tick,
  input  logic                hs_sel,
  input  logic                wr_en,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic                mute_n,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r,
  output logic [CODE_W-1:0]   cur_step
);
  localparam int NCH = 2;

  code_t code_q;
  logic  mute_nq;
  code_t tgt;
  code_t step;

  logic [SAMPLE_W-1:0] din_a  [NCH];
  logic [SAMPLE_W-1:0] dout_a [NCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q  <= '0;
      mute_nq <= 1'b1;
    end else begin
      mute_nq <= mute_n;
      if (wr_en) code_q <= wr_code;
    end
  end

  assign tgt = mute_nq ? code_q : code_t'(CODE_MAX);

  gr_step_ctrl #(
    .NORM_INTERVAL(NORM_INTERVAL),
    .HS_INTERVAL  (HS_INTERVAL)
  ) step_i (
    .clk   (clk),
    .rst   (rst),
    .tick  (smp_tick),
    .hs_sel(hs_sel),
    .tgt   (tgt),
    .cur   (step)
  );

  assign din_a[0] = in_l;
  assign din_a[1] = in_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    gr_chan_scale #(.SAMPLE_W(SAMPLE_W)) scale_i (
      .clk (clk),
      .rst (rst),
      .tick(smp_tick),
      .code(step),
      .din (din_a[ch]),
      .dout(dout_a[ch])
    );
  end

  assign out_l    = dout_a[0];
  assign out_r    = dout_a[1];
  assign cur_step = step;

  AST_MUTE_RISES_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(mute_nq) && step != $past(step)) |-> (step == $past(step) + code_t'(1))); // R5

  AST_MUTE_WRITE_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    !mute_nq |-> (tgt == code_t'(CODE_MAX))); // R6

  AST_RESET_OUTS: assert property (@(posedge clk)
    rst |=> (out_l == '0 && out_r == '0)); // R7
endmodule

// File: tb/gr_soft_atten_tb.sv
module gr_soft_atten_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_tick = 1'b0;
  logic        hs_sel = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_code = '0;
  logic        mute_n = 1'b1;
  logic [23:0] in_l = '0;
  logic [23:0] in_r = '0;
  logic [23:0] out_l, out_r;
  logic [6:0]  cur_step;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  gr_soft_atten dut_i (
    .clk(clk), .rst(rst), .smp_tick(smp_tick), .hs_sel(hs_sel),
    .wr_en(wr_en), .wr_code(wr_code), .mute_n(mute_n),
    .in_l(in_l), .in_r(in_r), .out_l(out_l), .out_r(out_r),
    .cur_step(cur_step)
  );

  localparam int NV = 6;
  localparam logic [6:0]  V_CODE [NV] = '{7'd0, 7'd1, 7'd63, 7'd126, 7'd127, 7'd64};
  localparam logic [23:0] V_L    [NV] = '{24'h123456, 24'h7FFFFF, 24'h400000,
                                          24'h000080, 24'h7FFFFF, 24'h000001};
  localparam logic [23:0] V_R    [NV] = '{24'hF00000, 24'h800000, 24'hFFFFFF,
                                          24'hFFFF80, 24'h800001, 24'hABCDEF};

  function automatic logic [23:0] exp_scale(input logic [6:0] c, input logic [23:0] x);
    longint p;
    int k;
    if (c == 7'd0)   return x;
    if (c == 7'd127) return 24'd0;
    k = 127 - int'(c);
    p = longint'($signed(x)) * longint'(k);
    p = p >>> 7;
    return p[23:0];
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) smp_tick = 1'b1;
    @(negedge clk) smp_tick = 1'b0;
  endtask

  task automatic do_write(input logic [6:0] c);
    @(negedge clk) begin wr_en = 1'b1; wr_code = c; end
    @(negedge clk) wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks_to(input logic [6:0] c, output int n);
    n = 0;
    while (cur_step != c && n < 5000) begin do_tick(); n++; end
  endtask

  task automatic ticks_to_change(output int n);
    logic [6:0] s;
    s = cur_step;
    n = 0;
    while (cur_step == s && n < 5000) begin do_tick(); n++; end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    #(150000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk("R7 reset outputs", out_l, 0);
    chk("R7 reset step", cur_step, 0);
    rst = 1'b0;
    @(negedge clk);

    // R7: unity after reset
    in_l = 24'h654321; in_r = 24'h9ABCDE;
    do_tick();
    chk("R7 unity left", out_l, 24'h654321);
    chk("R7 unity right", out_r, 24'h9ABCDE);

    // R1 table walk
    for (int i = 0; i < NV; i++) begin
      do_write(V_CODE[i]);
      ticks_to(V_CODE[i], n);
      in_l = V_L[i]; in_r = V_R[i];
      do_tick();
      chk("R1 scale left", out_l, exp_scale(V_CODE[i], V_L[i]));
      chk("R1 scale right", out_r, exp_scale(V_CODE[i], V_R[i]));
    end

    // R9: shared gain
    in_l = 24'h3C3C3C; in_r = 24'h3C3C3C;
    do_tick();
    chk("R9 equal channels", out_l, out_r);

    // R2/R4: full swing down 127->0 in high speed, then timing checks
    do_write(7'd127);
    ticks_to(7'd127, n);
    hs_sel = 1'b1;
    do_write(7'd0);
    ticks_to(7'd0, n);
    chk("R4 swing high-speed", n, 2032);
    hs_sel = 1'b0;
    do_write(7'd127);
    ticks_to(7'd127, n);
    chk("R4 swing normal", n, 1016);
    do_write(7'd0);
    ticks_to(7'd0, n);

    // R3: single step intervals
    do_write(7'd1);
    ticks_to_change(n);
    chk("R3 interval normal", n, 8);
    chk("R2 one step", cur_step, 1);
    hs_sel = 1'b1;
    do_write(7'd0);
    ticks_to_change(n);
    chk("R3 interval high-speed", n, 16);
    hs_sel = 1'b0;

    // R8: reversal mid-interval reloads counter
    do_write(7'd20);
    repeat (80) do_tick();
    chk("R8 before reversal", cur_step, 10);
    repeat (5) do_tick();
    do_write(7'd0);
    repeat (7) do_tick();
    chk("R8 no early step", cur_step, 10);
    do_tick();
    chk("R8 step after full interval", cur_step, 9);
    ticks_to(7'd0, n);

    // R5/R6: mute ramp, write while muted, release
    @(negedge clk) mute_n = 1'b0;
    repeat (400) do_tick();
    do_write(7'd40);
    chk("R6 still rising while muted", (cur_step >= 7'd50) ? 1 : 0, 1);
    ticks_to(7'd127, n);
    chk("R5 muted step", cur_step, 127);
    in_l = 24'h7FFFFF; in_r = 24'h800000;
    do_tick();
    chk("R5 muted output", out_l, 0);
    repeat (20) do_tick();
    chk("R6 held at silence", cur_step, 127);
    @(negedge clk) mute_n = 1'b1;
    ticks_to(7'd40, n);
    chk("R5 release duration", n, 696);
    repeat (20) do_tick();
    chk("R6 settled on new code", cur_step, 40);
    in_l = 24'h100000;
    do_tick();
    chk("R6 gain of new code", out_l, exp_scale(7'd40, 24'h100000));

    finish_run();
  end
endmodule